// File: doc/BRIEF.md
# Sleep-Mode Supply Monitor Duty Cycler

This block switches a supply-voltage detector (a low-voltage comparator and a precision power-on-reset comparator) on for short windows while the device sleeps. It runs on the system clock and advances on a 32 kHz enable tick. In each frame of N tick periods it opens a monitor window that lasts one tick period. A 2-bit code in a control register selects N. When the device is awake the monitor stays on all the time.

Two comparator bits come in through a two-flop synchronizer and are captured into a status register. While sleeping, that capture happens only during the monitor window. While awake, it happens on every cycle. The control register and the read-only status register sit in a secondary I/O bank. They respond only while the extended-bank select input is high.

Top module: `supmon_duty_top`

## Requirements
- R1: In sleep, the frame length in tick periods is set by control bits [7:6]: code 00 gives 128, 01 gives 512, 10 gives 32 and 11 gives 8. The monitor enable is high in exactly one tick period of each frame.
- R2: The control register is at address 0x1EB. Bits [7:6] are read/write. Writes to bits [5:0] are ignored, and those bits read as zero.
- R3: After reset the control register and the status register are zero. The frame position is at the start of a frame, so in sleep the enable is high until the first tick.
- R4: The status register is at address 0x1E4 and is read-only. Bit 1 is the low-voltage comparator, bit 0 is the power-on-reset comparator, and bits [7:2] read zero. A status bit of 1 means the comparator has tripped.
- R5: With the extended-bank select low, writes to both addresses are ignored and reads return 0x00.
- R6: A new duty code takes effect only when the current frame wraps. The frame in progress keeps its length.
- R7: While awake, a comparator change appears in the status register on the third rising clock edge after the input changes, and not earlier.
- R8: In sleep, the status register holds its value outside the monitor window and captures the synchronized comparators inside the window.
- R9: While awake, the monitor enable is held high.
- R10: The frame position advances only on a tick. The window opens on the tick that starts a frame and closes on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 32 kHz period enable, one clock wide |
| sleep_i | input | 1 | Device is in sleep mode |
| io_sel_i | input | 1 | Extended I/O bank select |
| addr_i | input | 9 | I/O address |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from the address |
| lvd_cmp_i | input | 1 | Low-voltage comparator output (asynchronous) |
| por_cmp_i | input | 1 | Power-on-reset comparator output (asynchronous) |
| mon_en_o | output | 1 | Monitor enable to the detection circuit |

## Verification
The assertions check on every cycle that:
- the frame position stays below the selected period and moves only on a tick;
- the active duty code changes only at a frame wrap;
- the status register holds while asleep outside the window;
- with the bank select low, reads return zero and writes leave the control register unchanged;
- reserved bits read zero.

Only the bench scenarios can show the exact frame lengths for each code and the three-edge synchronizer latency. They also show that a code written mid-frame lets the current frame finish, and that the enable pattern matches a tick-by-tick model under random sleep toggling and register traffic.

// File: rtl/supmon_pkg.sv
package supmon_pkg;
  parameter int unsigned ADDR_W = 9;
  parameter logic [ADDR_W-1:0] ADDR_CTRL = 9'h1EB;
  parameter logic [ADDR_W-1:0] ADDR_STAT = 9'h1E4;
  // log2 of frame length per duty code (non-monotonic encoding)
  parameter int unsigned LOG_C0 = 7;
  parameter int unsigned LOG_C1 = 9;
  parameter int unsigned LOG_C2 = 5;
  parameter int unsigned LOG_C3 = 3;
  localparam int unsigned CNT_W = 9;
  localparam int unsigned N_CMP = 2;

  typedef logic [1:0] duty_sel_t;

  function automatic int unsigned log_period(duty_sel_t s);
    case (s)
      2'b00:   return LOG_C0;
      2'b01:   return LOG_C1;
      2'b10:   return LOG_C2;
      default: return LOG_C3;
    endcase
  endfunction
endpackage

// File: rtl/supmon_frame.sv
module supmon_frame
  import supmon_pkg::*;
#(
  parameter int unsigned CW = CNT_W
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  duty_sel_t sel_i,
  output logic      win_o
);
  duty_sel_t        act_q;
  logic [CW-1:0]    pos_q;
  logic [CW-1:0]    last_pos;

  assign last_pos = CW'((32'd1 << log_period(act_q)) - 32'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      act_q <= 2'b00;
    end else if (tick_i) begin
      if (pos_q == last_pos) begin
        pos_q <= '0;
        act_q <= sel_i;
      end else begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  assign win_o = (pos_q == '0);

  assert_pos_in_frame_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q <= last_pos);
  assert_pos_tick_only_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(pos_q));
  assert_code_at_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tick_i && pos_q == last_pos) |=> $stable(act_q));
endmodule

// File: rtl/supmon_status.sv
module supmon_status
  import supmon_pkg::*;
#(
  parameter int unsigned NB     = N_CMP,
  parameter int unsigned STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NB-1:0] cmp_i,
  input  logic          upd_i,
  output logic [NB-1:0] status_o
);
  logic [NB-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[g] <= '0;
      else if (g == 0) stg_q[g] <= cmp_i;
      else stg_q[g] <= stg_q[(g == 0) ? 0 : g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    status_o <= '0;
    else if (upd_i) status_o <= stg_q[STAGES-1];
  end

  assert_status_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(status_o));
endmodule

// File: rtl/supmon_regs.sv
module supmon_regs
  import supmon_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              io_sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [7:0]        wdata_i,
  input  logic [N_CMP-1:0]  status_i,
  output duty_sel_t         sel_o,
  output logic [7:0]        rdata_o
);
  duty_sel_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= 2'b00;
    else if (wr_i && io_sel_i && addr_i == ADDR_CTRL) ctrl_q <= wdata_i[7:6];
  end

  always_comb begin
    rdata_o = 8'h00;
    if (io_sel_i) begin
      if (addr_i == ADDR_CTRL)      rdata_o = {ctrl_q, 6'b0};
      else if (addr_i == ADDR_STAT) rdata_o = {{(8-N_CMP){1'b0}}, status_i};
    end
  end

  assign sel_o = ctrl_q;

  assert_bank_gate_rd_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_sel_i |-> rdata_o == 8'h00);
  assert_bank_gate_wr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_sel_i |=> $stable(ctrl_q));
  assert_rsvd_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_CTRL) |-> rdata_o[5:0] == 6'b0);
  assert_stat_rsvd_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_STAT) |-> rdata_o[7:2] == 6'b0);
endmodule

// File: rtl/supmon_duty_top.sv
module supmon_duty_top
  import supmon_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       sleep_i,
  input  logic       io_sel_i,
  input  logic [8:0] addr_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       lvd_cmp_i,
  input  logic       por_cmp_i,
  output logic       mon_en_o
);
  duty_sel_t          sel;
  logic               win;
  logic [N_CMP-1:0]   status;

  supmon_regs u_regs (
    .clk_i, .rst_ni, .io_sel_i, .addr_i, .wr_i, .wdata_i,
    .status_i(status), .sel_o(sel), .rdata_o
  );

  supmon_frame u_frame (
    .clk_i, .rst_ni, .tick_i, .sel_i(sel), .win_o(win)
  );

  supmon_status u_status (
    .clk_i, .rst_ni, .cmp_i({lvd_cmp_i, por_cmp_i}),
    .upd_i(!sleep_i || win), .status_o(status)
  );

  assign mon_en_o = !sleep_i || win;

  assert_awake_on_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sleep_i |-> mon_en_o);
endmodule

// File: tb/sim_supmon_duty_top.sv
module sim_supmon_duty_top;
  logic clk = 0, rst_n = 0;
  logic tick = 0, sleep = 0, io_sel = 0, wr = 0, lvd = 0, por = 0;
  logic [8:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic mon_en;
  int n_run = 0, n_fail = 0;
  bit done = 0;
  int mpos = 0;
  logic [1:0] mact = 0, mctrl = 0;

  always #10 clk = ~clk;

  supmon_duty_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .sleep_i(sleep), .io_sel_i(io_sel),
    .addr_i(addr), .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata),
    .lvd_cmp_i(lvd), .por_cmp_i(por), .mon_en_o(mon_en)
  );

  function automatic int period(logic [1:0] c);
    case (c)
      2'b00: return 128;
      2'b01: return 512;
      2'b10: return 32;
      default: return 8;
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_tick();
    tick = 1;
    @(negedge clk);
    tick = 0;
    if (mpos == period(mact) - 1) begin mpos = 0; mact = mctrl; end
    else mpos++;
    check("R1/R10 enable", mon_en, (!sleep || mpos == 0) ? 1 : 0);
  endtask

  task automatic do_write(logic sel, logic [8:0] a, logic [7:0] d);
    io_sel = sel; addr = a; wdata = d; wr = 1;
    @(negedge clk);
    wr = 0;
    if (sel && a == 9'h1EB) mctrl = d[7:6];
  endtask

  task automatic do_read(logic sel, logic [8:0] a, output logic [7:0] d);
    io_sel = sel; addr = a;
    #1 d = rdata;
  endtask

  task automatic clocks(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [7:0] d;
    int highs;
    process::self().srandom(32'd1234);
    clocks(2);
    rst_n = 1;
    @(negedge clk);
    // R3 reset state
    do_read(1, 9'h1EB, d); check("R3 ctrl reset", d, 8'h00);
    do_read(1, 9'h1E4, d); check("R3 status reset", d, 8'h00);
    sleep = 1; #1;
    check("R3 window at start", mon_en, 1);
    // R9 awake
    sleep = 0; #1; check("R9 awake enable", mon_en, 1);
    sleep = 1;
    // R1 code 00: 256 ticks give 2 windows
    highs = 0;
    for (int i = 0; i < 256; i++) begin do_tick(); highs += mon_en; end
    check("R1 code00 windows", highs, 2);
    // R2 rw field, reserved ignored
    do_write(1, 9'h1EB, 8'hFF);
    do_read(1, 9'h1EB, d); check("R2 ctrl readback", d, 8'hC0);
    // R6 code 11 waits for wrap
    for (int i = 0; i < 5; i++) do_tick();
    check("R6 old frame kept", mon_en, 0);
    while (mpos != 0) do_tick();
    highs = 0;
    for (int i = 0; i < 32; i++) begin do_tick(); highs += mon_en; end
    check("R1 code11 windows", highs, 4);
    // R1 codes 10 and 01
    do_write(1, 9'h1EB, 8'h80);
    while (!(mpos == 0 && mact == 2'b10)) do_tick();
    highs = 0;
    for (int i = 0; i < 64; i++) begin do_tick(); highs += mon_en; end
    check("R1 code10 windows", highs, 2);
    do_write(1, 9'h1EB, 8'h40);
    while (!(mpos == 0 && mact == 2'b01)) do_tick();
    highs = 0;
    for (int i = 0; i < 512; i++) begin do_tick(); highs += mon_en; end
    check("R1 code01 windows", highs, 1);
    // R5 bank gating
    do_write(0, 9'h1EB, 8'hC0);
    do_read(1, 9'h1EB, d); check("R5 gated write", d, 8'h40);
    do_read(0, 9'h1EB, d); check("R5 gated read ctrl", d, 8'h00);
    // R7 latency while awake
    sleep = 0; lvd = 1; por = 0;
    clocks(2); do_read(1, 9'h1E4, d); check("R7 not before 3 edges", d, 8'h00);
    clocks(1); do_read(1, 9'h1E4, d); check("R7 lvd at bit1", d, 8'h02);
    lvd = 0; por = 1; clocks(3);
    do_read(1, 9'h1E4, d); check("R4 por at bit0", d, 8'h01);
    do_read(0, 9'h1E4, d); check("R5 gated read stat", d, 8'h00);
    // R4 read-only
    do_write(1, 9'h1E4, 8'hFF);
    do_read(1, 9'h1E4, d); check("R4 write ignored", d, 8'h01);
    // R8 hold outside window
    sleep = 1;
    if (mpos == 0) do_tick();
    lvd = 1; por = 0; clocks(6);
    do_read(1, 9'h1E4, d); check("R8 hold", d, 8'h01);
    while (mpos != 0) do_tick();
    clocks(1);
    do_read(1, 9'h1E4, d); check("R8 capture in window", d, 8'h02);
    // random mix
    for (int i = 0; i < 1500; i++) begin
      int op = $urandom_range(0, 9);
      if (op < 6) do_tick();
      else if (op == 6) do_write(1'($urandom_range(0, 1)),
                                 ($urandom_range(0, 1) != 0) ? 9'h1EB : 9'h1E4, 8'($urandom));
      else if (op == 7) begin
        do_read(1, 9'h1EB, d); check("R2 random readback", d, {mctrl, 6'b0});
      end else if (op == 8) begin
        sleep = ~sleep; #1;
        check("R9 enable vs sleep", mon_en, (!sleep || mpos == 0) ? 1 : 0);
      end else clocks(1);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 190000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule